// File: doc/BRIEF.md
# Parallel Bus Initiator Phase Sequencer

This block is the initiator (host) side control engine of an eight-bit, daisy-chained parallel peripheral bus that carries up to eight IDs, one bit of the data lines per ID. It watches the shared busy and select lines until the bus has been idle long enough. It then contends for ownership by placing only its own ID bit on the data lines, and selects a target. From there it follows whatever information phase the target signals on three control lines, and moves one byte per request/acknowledge handshake. A target that released the bus during a slow operation can later reconnect by reselecting the host. A bus reset line returns the sequencer to the idle state from anywhere.

The host side is a level `start_req` with a `target_id`, a byte to send (`tx_byte`, consumed on `tx_taken`), and a received byte (`rx_byte`, qualified by a one-cycle `rx_valid`). Bus inputs are the wired-OR of the other devices' drivers, and bus outputs are this device's drivers, with `db_oe` enabling the data lines. The bus phase is reported on `phase_o`.

The controller has seven states: IDLE (monitor the bus), ARB (contend), SEL (select the target), RESEL (answer a reselection), INFO (connected, waiting for a request), OUT_SETUP (present an output byte) and ACK (acknowledge held). The transitions are as follows. IDLE goes to RESEL on a valid reselection, and to ARB on a start request once the bus is free. ARB goes to SEL on a win and to IDLE on a loss. SEL goes to INFO when the target goes busy, and to IDLE on timeout. RESEL goes to INFO when select drops. INFO goes to ACK on an input request, to OUT_SETUP on an output request, and to IDLE when the target drops busy. OUT_SETUP always goes to ACK. ACK goes to INFO when the request drops. A bus reset takes any state to IDLE.

Top module: `pbus_initiator_seq`

## Requirements
- R1: Arbitration may begin only after busy, select and bus reset have all been low for FREE_CYC (default 4) consecutive clock edges. Arbitration starts on the edge after the bus is qualified free.
- R2: During arbitration the block asserts `bsy_o` and drives exactly one data bit, bit number `host_id`, for ARB_CYC (default 3) cycles. `phase_o` reads 1 throughout.
- R3: At the last arbitration edge the block loses if `sel_in` is high or any data bit above `host_id` is set. On a loss it releases every line and returns to `phase_o` = 0. Set bits below `host_id` do not stop a win.
- R4: After a win the block asserts `sel_o`, releases `bsy_o`, and drives bit `host_id` together with bit `target_id` (`phase_o` = 2). When `bsy_in` rises it drops `sel_o` and raises `connected_o`.
- R5: If `bsy_in` stays low for SEL_TMO (default 16) cycles of selection, the block abandons the attempt and returns to `phase_o` = 0.
- R6: While connected, `phase_o` decodes {`msg_in`,`cd_in`,`io_in`} as follows: 000 gives 5 (data out), 001 gives 6 (data in), 010 gives 4 (command), 011 gives 7 (status), 110 gives 8 (message out) and 111 gives 9 (message in). The codes 100 and 101 give 10 (reserved).
- R7: An input request (`req_in` with `io_in`=1) latches `db_in` into `rx_byte`, pulses `rx_valid` for one cycle and raises `ack_o` on the same edge. `ack_o` stays high until `req_in` falls and drops on the next edge.
- R8: An output request (`req_in` with `io_in`=0) drives the byte captured from `tx_byte` on the data lines for one cycle with `ack_o` low and `tx_taken` high. It then raises `ack_o` and keeps driving the same byte until `req_in` falls.
- R9: When `bsy_in` falls while the block is connected and waiting, it returns to `phase_o` = 0.
- R10: In idle, if `sel_in` is high, `bsy_in` low, `io_in` high, and the data lines carry exactly two bits, one of them bit `host_id`, the block asserts `bsy_o` (`phase_o` = 3) and reports the other bit's number on `resel_id`. When `sel_in` falls it releases `bsy_o` and becomes connected.
- R11: A select with the own bit missing, with other than two bits set, or with `io_in` low does not cause a reselection. `bsy_o` stays low.
- R12: `rst_line_in` forces, on the next edge, `phase_o` = 0 and `bsy_o`, `sel_o`, `ack_o` and `db_oe` low, from any state.
- R13: After `rst_n` all bus outputs are low, `connected_o` is low and `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_id | input | ID_W | This device's ID |
| start_req | input | 1 | Host requests a connection (level) |
| target_id | input | ID_W | ID to select |
| tx_byte | input | N_IDS | Byte for the next output transfer |
| bsy_in | input | 1 | Busy line from other devices |
| sel_in | input | 1 | Select line from other devices |
| rst_line_in | input | 1 | Bus reset line |
| req_in | input | 1 | Target request |
| cd_in | input | 1 | Target control/data line |
| io_in | input | 1 | Target direction line (1 = to initiator) |
| msg_in | input | 1 | Target message line |
| db_in | input | N_IDS | Data lines from other devices |
| bsy_o | output | 1 | Busy driver |
| sel_o | output | 1 | Select driver |
| ack_o | output | 1 | Acknowledge driver |
| db_oe | output | 1 | Data line drive enable |
| db_o | output | N_IDS | Data line driver value |
| phase_o | output | 4 | Current bus phase code |
| connected_o | output | 1 | Connected to a target |
| rx_byte | output | N_IDS | Last received byte |
| rx_valid | output | 1 | One-cycle pulse for a new `rx_byte` |
| tx_taken | output | 1 | `tx_byte` consumed this cycle |
| resel_id | output | ID_W | ID of the reselecting target |

## Verification
The assertions rely on the target behaving as a target should. The target keeps `req_in` high until it sees `ack_o`. Contenders raise their own busy while they arbitrate. Reselection comes only from a bus that is otherwise idle. The stimulus drives every bus input at the falling edge and holds the request through the whole output setup cycle. It raises `bsy_in` for a losing contender, so that the bus is not seen as free again at once. It also drops `start_req` before selection can time out, so that a failed attempt does not restart arbitration immediately.

// File: rtl/pbus_seq_pkg.sv
package pbus_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_SEL,
        S_RESEL,
        S_INFO,
        S_OUT_SETUP,
        S_ACK
    } seq_state_t;

    typedef enum logic [3:0] {
        PH_FREE  = 4'd0,
        PH_ARB   = 4'd1,
        PH_SEL   = 4'd2,
        PH_RESEL = 4'd3,
        PH_CMD   = 4'd4,
        PH_DOUT  = 4'd5,
        PH_DIN   = 4'd6,
        PH_STAT  = 4'd7,
        PH_MOUT  = 4'd8,
        PH_MIN   = 4'd9,
        PH_RSVD  = 4'd10
    } bus_phase_t;
endpackage

// File: rtl/pbus_free_detect.sv
module pbus_free_detect #(
    parameter int FREE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsy_line,
    input  logic sel_line,
    input  logic rst_line,
    output logic bus_free
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(FREE_CYC + 1);

    logic [CW-1:0] quiet_cnt;

    // Count consecutive quiet edges, saturate at the qualification length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (bsy_line || sel_line || rst_line) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != CW'(FREE_CYC)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign bus_free = (quiet_cnt == CW'(FREE_CYC));
endmodule

// File: rtl/pbus_arb_resolver.sv
module pbus_arb_resolver #(
    parameter int N_IDS = 8,
    parameter int ID_W  = $clog2(N_IDS)
) (
    input  logic [N_IDS-1:0] db_line,
    input  logic [ID_W-1:0]  own_id,
    output logic [N_IDS-1:0] own_mask,
    output logic             higher_seen,
    output logic             own_seen,
    output logic             pair_seen,
    output logic [ID_W-1:0]  other_id
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N_IDS-1:0] above_mask;
    logic [N_IDS-1:0] others;

    for (genvar g = 0; g < N_IDS; g++) begin : g_bit
        assign own_mask[g]   = (own_id == ID_W'(g));
        assign above_mask[g] = (ID_W'(g) > own_id);
    end

    assign higher_seen = |(db_line & above_mask);
    assign own_seen    = |(db_line & own_mask);
    assign pair_seen   = ($countones(db_line) == 2);
    assign others      = db_line & ~own_mask;

    // Number of the highest bit that is not our own
    always_comb begin
        other_id = '0;
        for (int i = 0; i < N_IDS; i++) begin
            if (others[i]) begin
                other_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/pbus_phase_decode.sv
module pbus_phase_decode
    import pbus_seq_pkg::*;
(
    input  logic       msg_line,
    input  logic       cd_line,
    input  logic       io_line,
    output bus_phase_t phase,
    output logic       to_host
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        phase = PH_RSVD;
        unique case ({msg_line, cd_line, io_line})
            3'b000: phase = PH_DOUT;
            3'b001: phase = PH_DIN;
            3'b010: phase = PH_CMD;
            3'b011: phase = PH_STAT;
            3'b110: phase = PH_MOUT;
            3'b111: phase = PH_MIN;
            3'b100,
            3'b101: phase = PH_RSVD;
        endcase
    end

    assign to_host = io_line;
endmodule

// File: rtl/pbus_initiator_seq.sv
module pbus_initiator_seq
    import pbus_seq_pkg::*;
#(
    parameter int N_IDS    = 8,
    parameter int FREE_CYC = 4,
    parameter int ARB_CYC  = 3,
    parameter int SEL_TMO  = 16,
    parameter int ID_W     = $clog2(N_IDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  host_id,
    input  logic             start_req,
    input  logic [ID_W-1:0]  target_id,
    input  logic [N_IDS-1:0] tx_byte,
    input  logic             bsy_in,
    input  logic             sel_in,
    input  logic             rst_line_in,
    input  logic             req_in,
    input  logic             cd_in,
    input  logic             io_in,
    input  logic             msg_in,
    input  logic [N_IDS-1:0] db_in,
    output logic             bsy_o,
    output logic             sel_o,
    output logic             ack_o,
    output logic             db_oe,
    output logic [N_IDS-1:0] db_o,
    output logic [3:0]       phase_o,
    output logic             connected_o,
    output logic [N_IDS-1:0] rx_byte,
    output logic             rx_valid,
    output logic             tx_taken,
    output logic [ID_W-1:0]  resel_id
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TMR_MAX  = (SEL_TMO > ARB_CYC) ? SEL_TMO : ARB_CYC;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int ARB_LAST = ARB_CYC - 1;
    localparam int SEL_LAST = SEL_TMO - 1;

    seq_state_t       state;
    seq_state_t       nxt_state;
    logic [TMR_W-1:0] tmr;
    logic             tmr_run;
    logic [N_IDS-1:0] tx_q;
    logic             drive_q;

    logic             bus_free;
    logic [N_IDS-1:0] own_mask;
    logic [N_IDS-1:0] tgt_mask;
    logic             higher_seen;
    logic             own_seen;
    logic             pair_seen;
    logic [ID_W-1:0]  other_id;
    bus_phase_t       line_phase;
    logic             to_host;
    logic             resel_hit;
    logic             in_byte;

    pbus_free_detect #(
        .FREE_CYC (FREE_CYC)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .bsy_line (bsy_in),
        .sel_line (sel_in),
        .rst_line (rst_line_in),
        .bus_free (bus_free)
    );

    pbus_arb_resolver #(
        .N_IDS (N_IDS),
        .ID_W  (ID_W)
    ) u_arb (
        .db_line     (db_in),
        .own_id      (host_id),
        .own_mask    (own_mask),
        .higher_seen (higher_seen),
        .own_seen    (own_seen),
        .pair_seen   (pair_seen),
        .other_id    (other_id)
    );

    pbus_phase_decode u_dec (
        .msg_line (msg_in),
        .cd_line  (cd_in),
        .io_line  (io_in),
        .phase    (line_phase),
        .to_host  (to_host)
    );

    for (genvar g = 0; g < N_IDS; g++) begin : g_tgt
        assign tgt_mask[g] = (target_id == ID_W'(g));
    end

    assign resel_hit = sel_in && !bsy_in && io_in && own_seen && pair_seen;
    assign in_byte   = (state == S_INFO) && !rst_line_in && bsy_in && req_in && to_host;
    assign tmr_run   = (state == S_ARB) || (state == S_SEL);

    // Next-state logic
    always_comb begin
        nxt_state = state;
        if (rst_line_in) begin
            nxt_state = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (resel_hit) begin
                        nxt_state = S_RESEL;
                    end else if (start_req && bus_free) begin
                        nxt_state = S_ARB;
                    end
                end
                S_ARB: begin
                    if (tmr == TMR_W'(ARB_LAST)) begin
                        nxt_state = (sel_in || higher_seen) ? S_IDLE : S_SEL;
                    end
                end
                S_SEL: begin
                    if (bsy_in) begin
                        nxt_state = S_INFO;
                    end else if (tmr == TMR_W'(SEL_LAST)) begin
                        nxt_state = S_IDLE;
                    end
                end
                S_RESEL: begin
                    if (!sel_in) begin
                        nxt_state = S_INFO;
                    end
                end
                S_INFO: begin
                    if (!bsy_in) begin
                        nxt_state = S_IDLE;
                    end else if (req_in) begin
                        nxt_state = to_host ? S_ACK : S_OUT_SETUP;
                    end
                end
                S_OUT_SETUP: begin
                    nxt_state = S_ACK;
                end
                S_ACK: begin
                    if (!req_in) begin
                        nxt_state = S_INFO;
                    end
                end
                default: begin
                    nxt_state = S_IDLE;
                end
            endcase
        end
    end

    // State register and the data held with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tmr      <= '0;
            tx_q     <= '0;
            drive_q  <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            resel_id <= '0;
        end else begin
            state <= nxt_state;

            if (nxt_state != state) begin
                tmr <= '0;
            end else if (tmr_run) begin
                tmr <= tmr + 1'b1;
            end

            if (state == S_INFO && nxt_state == S_OUT_SETUP) begin
                tx_q <= tx_byte;
            end

            if (nxt_state == S_OUT_SETUP) begin
                drive_q <= 1'b1;
            end else if (nxt_state != S_ACK) begin
                drive_q <= 1'b0;
            end

            rx_valid <= in_byte;
            if (in_byte) begin
                rx_byte <= db_in;
            end

            if (state == S_IDLE && nxt_state == S_RESEL) begin
                resel_id <= other_id;
            end
        end
    end

    // Moore outputs
    always_comb begin
        bsy_o       = 1'b0;
        sel_o       = 1'b0;
        ack_o       = 1'b0;
        db_oe       = 1'b0;
        db_o        = '0;
        tx_taken    = 1'b0;
        connected_o = 1'b0;
        phase_o     = PH_FREE;
        unique case (state)
            S_IDLE: begin
                phase_o = PH_FREE;
            end
            S_ARB: begin
                bsy_o   = 1'b1;
                db_oe   = 1'b1;
                db_o    = own_mask;
                phase_o = PH_ARB;
            end
            S_SEL: begin
                sel_o   = 1'b1;
                db_oe   = 1'b1;
                db_o    = own_mask | tgt_mask;
                phase_o = PH_SEL;
            end
            S_RESEL: begin
                bsy_o   = 1'b1;
                phase_o = PH_RESEL;
            end
            S_INFO: begin
                connected_o = 1'b1;
                phase_o     = line_phase;
            end
            S_OUT_SETUP: begin
                connected_o = 1'b1;
                db_oe       = 1'b1;
                db_o        = tx_q;
                tx_taken    = 1'b1;
                phase_o     = line_phase;
            end
            S_ACK: begin
                connected_o = 1'b1;
                ack_o       = 1'b1;
                db_oe       = drive_q;
                db_o        = drive_q ? tx_q : '0;
                phase_o     = line_phase;
            end
            default: begin
                phase_o = PH_FREE;
            end
        endcase
    end
endmodule

// File: rtl/pbus_seq_checker.sv
module pbus_seq_checker #(
    parameter int N_IDS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bsy_o,
    input logic             sel_o,
    input logic             ack_o,
    input logic             db_oe,
    input logic [N_IDS-1:0] db_o,
    input logic             req_in,
    input logic             rst_line_in,
    input logic             rx_valid,
    input logic             bus_free
);
    timeunit 1ns;
    timeprecision 1ps;

    // R1: arbitration begins only from a qualified free bus
    p_arb_from_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_o && db_oe && !$past(bsy_o)) |-> $past(bus_free));

    // R2: a single ID bit while contending
    p_arb_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_o && db_oe) |-> ($countones(db_o) == 1));

    // R4: selection follows directly on arbitration
    p_sel_after_arb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && !$past(sel_o)) |-> ($past(bsy_o) && $past(db_oe)));

    // R7: acknowledge only answers a request
    p_ack_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_in));

    // R7: acknowledge released after request drops
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_in && !rst_line_in) |=> !ack_o);

    // R7: received byte is flagged together with acknowledge
    p_rx_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ack_o);

    // R8: driven byte held steady while acknowledged
    p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && db_oe) |-> $stable(db_o));

    // R12: bus reset clears every driver on the next edge
    p_bus_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_line_in |=> (!bsy_o && !sel_o && !ack_o && !db_oe));
endmodule

bind pbus_initiator_seq pbus_seq_checker #(
    .N_IDS (N_IDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bsy_o       (bsy_o),
    .sel_o       (sel_o),
    .ack_o       (ack_o),
    .db_oe       (db_oe),
    .db_o        (db_o),
    .req_in      (req_in),
    .rst_line_in (rst_line_in),
    .rx_valid    (rx_valid),
    .bus_free    (bus_free)
);

// File: tb/pbus_initiator_seq_tb_top.sv
module pbus_initiator_seq_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_IDS = 8;
    localparam int ID_W  = 3;

    // {msg, cd, io, expected phase code}
    localparam logic [6:0] PH_TAB [8] = '{
        7'b000_0101, 7'b001_0110, 7'b010_0100, 7'b011_0111,
        7'b100_1010, 7'b101_1010, 7'b110_1000, 7'b111_1001
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [ID_W-1:0]  host_id;
    logic             start_req;
    logic [ID_W-1:0]  target_id;
    logic [N_IDS-1:0] tx_byte;
    logic             bsy_in, sel_in, rst_line_in, req_in, cd_in, io_in, msg_in;
    logic [N_IDS-1:0] db_in;
    logic             bsy_o, sel_o, ack_o, db_oe;
    logic [N_IDS-1:0] db_o;
    logic [3:0]       phase_o;
    logic             connected_o;
    logic [N_IDS-1:0] rx_byte;
    logic             rx_valid, tx_taken;
    logic [ID_W-1:0]  resel_id;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    pbus_initiator_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_id(host_id), .start_req(start_req),
        .target_id(target_id), .tx_byte(tx_byte), .bsy_in(bsy_in), .sel_in(sel_in),
        .rst_line_in(rst_line_in), .req_in(req_in), .cd_in(cd_in), .io_in(io_in),
        .msg_in(msg_in), .db_in(db_in), .bsy_o(bsy_o), .sel_o(sel_o), .ack_o(ack_o),
        .db_oe(db_oe), .db_o(db_o), .phase_o(phase_o), .connected_o(connected_o),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_taken(tx_taken), .resel_id(resel_id)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic nx(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic quiet_bus();
        bsy_in = 0; sel_in = 0; req_in = 0; db_in = '0;
        cd_in = 0; io_in = 0; msg_in = 0; rst_line_in = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_id = 3'd5; target_id = 3'd2; tx_byte = '0; start_req = 1;
        quiet_bus();
        bsy_in = 1;
        nx(3);
        rst_n = 1;
        nx(1);
        // R13 reset state
        chk("R13 phase", 32'(phase_o), 32'd0);
        chk("R13 drivers", 32'({bsy_o, sel_o, ack_o, db_oe, connected_o}), 32'd0);
        nx(1);

        // R1 free qualification then R2 arbitration
        bsy_in = 0;
        nx(4);
        chk("R1 no arbitration before free", 32'(bsy_o), 32'd0);
        nx(1);
        chk("R1 arbitration after free", 32'(bsy_o), 32'd1);
        chk("R2 own bit", 32'(db_o), 32'h20);
        chk("R2 phase", 32'(phase_o), 32'd1);
        db_in = 8'h04; bsy_in = 1;   // lower contender
        nx(2);
        chk("R2 still contending", 32'({bsy_o, db_oe, db_o}), 32'({1'b1, 1'b1, 8'h20}));
        nx(1);
        // R3 lower bits ignored, R4 selection
        chk("R3 win over lower id", 32'(phase_o), 32'd2);
        chk("R4 selection lines", 32'({sel_o, bsy_o, db_o}), 32'({1'b1, 1'b0, 8'h24}));
        db_in = '0; bsy_in = 0; start_req = 0;
        nx(1);
        chk("R4 waiting for target", 32'(sel_o), 32'd1);
        bsy_in = 1;
        nx(1);
        chk("R4 connected", 32'({connected_o, sel_o}), 32'({1'b1, 1'b0}));

        // R6 phase decode table
        for (int i = 0; i < 8; i++) begin
            {msg_in, cd_in, io_in} = PH_TAB[i][6:4];
            #1;
            chk("R6 phase decode", 32'(phase_o), 32'(PH_TAB[i][3:0]));
            nx(1);
        end
        {msg_in, cd_in, io_in} = 3'b000;

        // R7 input byte
        io_in = 1; db_in = 8'hA5; req_in = 1;
        nx(1);
        chk("R7 ack and valid", 32'({ack_o, rx_valid}), 32'({1'b1, 1'b1}));
        chk("R7 rx byte", 32'(rx_byte), 32'hA5);
        nx(1);
        chk("R7 valid single cycle", 32'({ack_o, rx_valid}), 32'({1'b1, 1'b0}));
        req_in = 0; db_in = '0;
        nx(1);
        chk("R7 ack released", 32'({ack_o, connected_o}), 32'({1'b0, 1'b1}));

        // R8 output byte
        io_in = 0; tx_byte = 8'h3C; req_in = 1;
        nx(1);
        chk("R8 setup", 32'({db_oe, ack_o, tx_taken, db_o}), 32'({1'b1, 1'b0, 1'b1, 8'h3C}));
        tx_byte = 8'hFF;
        nx(1);
        chk("R8 ack with data", 32'({db_oe, ack_o, tx_taken, db_o}), 32'({1'b1, 1'b1, 1'b0, 8'h3C}));
        req_in = 0;
        nx(1);
        chk("R8 release", 32'({db_oe, ack_o}), 32'd0);

        // R9 disconnect
        bsy_in = 0;
        nx(1);
        chk("R9 disconnect", 32'({phase_o, connected_o}), 32'd0);
        nx(2);

        // R10 reselection by target 6
        sel_in = 1; io_in = 1; db_in = 8'h60;
        nx(1);
        chk("R10 answer", 32'({bsy_o, phase_o}), 32'({1'b1, 4'd3}));
        chk("R10 resel id", 32'(resel_id), 32'd6);
        bsy_in = 1;
        nx(1);
        chk("R10 hold", 32'(bsy_o), 32'd1);
        sel_in = 0; db_in = '0;
        nx(1);
        chk("R10 connected", 32'({connected_o, bsy_o, phase_o}), 32'({1'b1, 1'b0, 4'd6}));

        // R12 bus reset mid-transfer
        req_in = 1;
        nx(1);
        chk("R12 pre ack", 32'(ack_o), 32'd1);
        rst_line_in = 1;
        nx(1);
        chk("R12 abort", 32'({ack_o, db_oe, connected_o, phase_o}), 32'd0);
        quiet_bus();
        nx(2);

        // R11 invalid reselections
        sel_in = 1; io_in = 1; db_in = 8'h41;
        nx(1);
        chk("R11 own bit missing", 32'({bsy_o, phase_o}), 32'd0);
        db_in = 8'h61;
        nx(1);
        chk("R11 three bits", 32'({bsy_o, phase_o}), 32'd0);
        db_in = 8'h60; io_in = 0;
        nx(1);
        chk("R11 wrong direction", 32'({bsy_o, phase_o}), 32'd0);
        quiet_bus();
        nx(6);

        // R3 loss to higher id
        start_req = 1;
        nx(1);
        chk("R3 arbitrating", 32'(phase_o), 32'd1);
        db_in = 8'h40; bsy_in = 1;
        nx(3);
        chk("R3 lost to higher", 32'({bsy_o, db_oe, phase_o}), 32'd0);
        start_req = 0; quiet_bus();
        nx(6);

        // R3 loss to select seen
        start_req = 1;
        nx(1);
        sel_in = 1; bsy_in = 1;
        nx(3);
        chk("R3 lost to select", 32'({bsy_o, sel_o, phase_o}), 32'd0);
        start_req = 0; quiet_bus();
        nx(6);

        // R5 selection timeout
        start_req = 1;
        nx(1);
        start_req = 0;
        nx(3);
        chk("R5 selecting", 32'(sel_o), 32'd1);
        nx(15);
        chk("R5 before timeout", 32'(sel_o), 32'd1);
        nx(1);
        chk("R5 timeout", 32'({sel_o, phase_o}), 32'd0);
        nx(6);

        // R12 bus reset during arbitration
        start_req = 1;
        nx(1);
        chk("R12 arbitrating", 32'(bsy_o), 32'd1);
        rst_line_in = 1;
        nx(1);
        chk("R12 arbitration aborted", 32'({bsy_o, db_oe, phase_o}), 32'd0);
        start_req = 0; quiet_bus();
        nx(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule